// File: doc/BRIEF.md
# Multi-Controller Instruction Steering Unit

This block is the front end of one processing element in an array driven by several instruction controllers at once. Every controller broadcasts its own instruction word and a valid bit to all elements in the same cycle. Each element follows exactly one of those streams at a time and passes that stream's instruction to its datapath. Its local data never alters what a controller sends. It only decides which stream the element listens to.

The stream being followed is held in a small select register. That register changes only when the followed stream issues a dedicated steer instruction. The steer instruction carries two candidate controller numbers, and a test flag computed from the element's own data picks between them. The new choice applies from the next cycle onward. Register operand indices in the chosen instruction are also remapped so that each controller works in its own window of eight registers.

Instruction layout, with the defaults of 32-bit words and 4 controllers: the opcode is in bits [31:26], the destination index in [25:23], the first source in [22:20] and the second source in [19:17]. The steer opcode is 6'b111111. A steer instruction holds its flag-true target in bits [1:0] and its flag-false target in bits [9:8].

Top module: `pe_ctrl_steer`

## Requirements
- R1: After reset the select output is 0, so controller 0 is followed.
- R2: When the followed controller's valid bit is 1, the issue output is 1 and the instruction output equals that controller's word in the same cycle, whatever the other controllers send.
- R3: When the followed controller's valid bit is 0, the issue output is 0, the instruction output is all zeros (a no-op), and the select register keeps its value across the edge.
- R4: A steer instruction (opcode 6'b111111) issued from the followed stream loads the select register at the clock edge with bits [1:0] when the test flag is 1, and with bits [9:8] when the test flag is 0.
- R5: In the cycle a steer instruction is issued, the outputs still come from the previously selected controller. The new selection is used from the next cycle.
- R6: A steer instruction from a controller that is not followed leaves the select register unchanged.
- R7: While issuing, each physical register index output equals select*8 plus the matching logical index field. While not issuing, the index outputs are zero.
- R8: An issued instruction whose opcode is not the steer opcode leaves the select register unchanged, whatever the test flag is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_instr_i | input | NCTRL*IW | Broadcast words; controller k occupies bits [k*IW +: IW] |
| ctl_valid_i | input | NCTRL | Per-controller valid bits |
| test_flag_i | input | 1 | Local data test result used by steer instructions |
| instr_o | output | IW | Selected instruction, or zero when no-op |
| issue_o | output | 1 | Active enable for the datapath |
| sel_o | output | CW | Controller currently followed |
| rd_phys_o | output | CW+3 | Remapped destination index |
| rs1_phys_o | output | CW+3 | Remapped first source index |
| rs2_phys_o | output | CW+3 | Remapped second source index |

## Verification
The bench puts steer instructions on streams that are not followed, including one that arrives in a no-op cycle. A design that decoded every stream, or ignored the valid bit, would jump to another controller there. It checks the outputs during the steer cycle itself, where a design that forwarded the new selection combinationally would return the wrong controller's word. It exercises both polarities of the test flag, which catches swapped target fields. It also checks the window remap after a move to controllers 2 and 3, where a missing or shifted offset shows up directly in the physical index.

// File: rtl/pe_ctrl_steer.sv
module pe_ctrl_steer #(
  parameter int NCTRL = 4,
  parameter int IW    = 32,
  parameter int WIN   = 8,
  parameter int OPW   = 6,
  parameter logic [OPW-1:0] STEER_OP = '1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NCTRL*IW-1:0]                  ctl_instr_i,
  input  logic [NCTRL-1:0]                     ctl_valid_i,
  input  logic                                 test_flag_i,
  output logic [IW-1:0]                        instr_o,
  output logic                                 issue_o,
  output logic [$clog2(NCTRL)-1:0]             sel_o,
  output logic [$clog2(NCTRL)+$clog2(WIN)-1:0] rd_phys_o,
  output logic [$clog2(NCTRL)+$clog2(WIN)-1:0] rs1_phys_o,
  output logic [$clog2(NCTRL)+$clog2(WIN)-1:0] rs2_phys_o
);
  localparam int CW      = $clog2(NCTRL);
  localparam int LW      = $clog2(WIN);
  localparam int OP_LSB  = IW - OPW;
  localparam int RD_LSB  = OP_LSB - LW;
  localparam int RS1_LSB = RD_LSB - LW;
  localparam int RS2_LSB = RS1_LSB - LW;
  localparam int FT_LSB  = 8;

  logic [CW-1:0] sel_q;
  logic [IW-1:0] cur;
  logic          steer;
  logic [CW-1:0] tgt;

  assign cur     = ctl_instr_i[sel_q*IW +: IW];
  assign issue_o = ctl_valid_i[sel_q];
  assign instr_o = issue_o ? cur : '0;
  assign sel_o   = sel_q;
  assign steer   = issue_o && (cur[OP_LSB +: OPW] == STEER_OP);
  assign tgt     = test_flag_i ? cur[CW-1:0] : cur[FT_LSB +: CW];

  assign rd_phys_o  = issue_o ? {sel_q, cur[RD_LSB  +: LW]} : '0;
  assign rs1_phys_o = issue_o ? {sel_q, cur[RS1_LSB +: LW]} : '0;
  assign rs2_phys_o = issue_o ? {sel_q, cur[RS2_LSB +: LW]} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (steer) sel_q <= tgt;
  end

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid_i[sel_o] |-> (issue_o && instr_o == ctl_instr_i[sel_o*IW +: IW]));

  assert_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_valid_i[sel_o] |-> (!issue_o && instr_o == '0 && rd_phys_o == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_o |=> $stable(sel_o));

  assert_steer_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && instr_o[OP_LSB +: OPW] == STEER_OP && test_flag_i)
      |=> sel_o == $past(instr_o[CW-1:0]));

  assert_steer_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && instr_o[OP_LSB +: OPW] == STEER_OP && !test_flag_i)
      |=> sel_o == $past(instr_o[FT_LSB +: CW]));

  assert_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> (rs1_phys_o[LW +: CW] == sel_o && rs2_phys_o[LW +: CW] == sel_o));

  assert_other_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && instr_o[OP_LSB +: OPW] != STEER_OP) |=> $stable(sel_o));
endmodule

// File: tb/tb_pe_ctrl_steer.sv
module tb_pe_ctrl_steer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] w [4];
  logic [3:0]  vld = '0;
  logic        flag = 0;
  logic [127:0] bus;
  logic [31:0] instr;
  logic        issue;
  logic [1:0]  sel;
  logic [4:0]  rd, rs1, rs2;
  int checks = 0, fails = 0;

  assign bus = {w[3], w[2], w[1], w[0]};
  always #5 clk = ~clk;

  pe_ctrl_steer dut (.clk(clk), .rst_n(rst_n), .ctl_instr_i(bus), .ctl_valid_i(vld),
    .test_flag_i(flag), .instr_o(instr), .issue_o(issue), .sel_o(sel),
    .rd_phys_o(rd), .rs1_phys_o(rs1), .rs2_phys_o(rs2));

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [2:0] a,
                                     input logic [2:0] b, input logic [2:0] c,
                                     input logic [16:0] imm);
    return {op, a, b, c, imm};
  endfunction

  function automatic logic [31:0] steer_w(input logic [1:0] t, input logic [1:0] f);
    return mk(6'h3F, 3'd0, 3'd0, 3'd0, {7'd0, f, 6'd0, t});
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic t_reset();
    w[0] = mk(6'h01, 3'd1, 3'd2, 3'd3, 17'h0); w[1] = 32'h1111_1111;
    w[2] = 32'h2222_2222; w[3] = 32'h3333_3333; vld = 4'hF;
    #1;
    chk("R1 sel after reset", 32'(sel), 32'd0);
    chk("R1 issue after reset", 32'(issue), 32'd1);
  endtask

  task automatic t_pass();
    w[0] = mk(6'h05, 3'd7, 3'd4, 3'd2, 17'h1234); #1;
    chk("R2 instr from ctl0", instr, w[0]);
    chk("R7 rd window 0", 32'(rd), 32'd7);
    chk("R7 rs1 window 0", 32'(rs1), 32'd4);
    chk("R7 rs2 window 0", 32'(rs2), 32'd2);
  endtask

  task automatic t_invalid();
    vld = 4'b1110; w[1] = steer_w(2'd1, 2'd1); w[2] = steer_w(2'd2, 2'd2);
    w[0] = steer_w(2'd3, 2'd3); flag = 1; #1;
    chk("R3 issue low", 32'(issue), 32'd0);
    chk("R3 nop word", instr, 32'd0);
    chk("R7 idx zero when idle", 32'(rd), 32'd0);
    tick();
    chk("R3 sel held on nop", 32'(sel), 32'd0);
  endtask

  task automatic t_steer_true();
    vld = 4'hF; w[0] = steer_w(2'd2, 2'd1); flag = 1;
    w[2] = mk(6'h02, 3'd5, 3'd6, 3'd1, 17'h0); #1;
    chk("R5 steer cycle still ctl0", instr, w[0]);
    chk("R5 sel unchanged in steer cycle", 32'(sel), 32'd0);
    tick();
    chk("R4 flag=1 picks true target", 32'(sel), 32'd2);
    chk("R2 instr from ctl2", instr, w[2]);
    chk("R7 rd window 2", 32'(rd), 32'd21);
    chk("R7 rs1 window 2", 32'(rs1), 32'd22);
    chk("R7 rs2 window 2", 32'(rs2), 32'd17);
  endtask

  task automatic t_steer_false();
    w[2] = steer_w(2'd0, 2'd3); flag = 0;
    w[3] = mk(6'h03, 3'd3, 3'd0, 3'd7, 17'h0); tick();
    chk("R4 flag=0 picks false target", 32'(sel), 32'd3);
    chk("R7 rd window 3", 32'(rd), 32'd27);
    chk("R7 rs2 window 3", 32'(rs2), 32'd31);
  endtask

  task automatic t_ignored();
    w[0] = steer_w(2'd0, 2'd0); w[1] = steer_w(2'd1, 2'd1); w[2] = steer_w(2'd2, 2'd2);
    w[3] = mk(6'h3E, 3'd1, 3'd1, 3'd1, 17'h1); flag = 1; tick();
    chk("R6 other streams steer ignored", 32'(sel), 32'd3);
    chk("R8 non-steer op keeps sel", 32'(sel), 32'd3);
    flag = 0; tick();
    chk("R8 non-steer op keeps sel flag0", 32'(sel), 32'd3);
    chk("R2 ctl3 word still out", instr, w[3]);
  endtask

  initial begin
    fork
      begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1; @(negedge clk);
        t_pass(); t_invalid(); t_steer_true(); t_steer_false(); t_ignored();
      end
      begin
        repeat (2000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule